// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block collects 32 hardware request lines and turns them into one CPU interrupt line plus the number of the source the CPU should serve first. Each line passes through a two-flop synchronizer. A per-source configuration word then treats it either as a level (the live synchronized input, corrected for polarity) or as an edge (a sticky request that stays set until software clears it). Source 0 is never used. Source 31 has no configuration word and always acts as an active-high level input.

Priority does not come from bit position. Software writes a source number into each of 31 priority slots, and slot 1 is the most urgent. Each slot has its own level enable. A source that is latched and enabled raises the CPU line only when it sits in an enabled slot. Bit 0 of the level-enable word is a freeze control: while it is set, the interrupt line and the vector hold their values.

All registers sit on a simple word bus made of address, write data, write strobe and read data. Reads are combinational. Enables change only through write-one-to-set and write-one-to-clear registers.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the source enables, the level enables, the sticky requests, the priority slots and the configuration words are all zero, and `cpu_irq` and `irq_vector` are 0.
- R2: A write to 0x184 sets the enable bits where the data is 1. A write to 0x188 clears the enable bits where the data is 1. Bits written as 0 are unchanged. A read of 0x184 returns the enable mask.
- R3: A write to 0x18C clears the sticky request of every edge source whose data bit is 1. It has no effect on level sources.
- R4: Slot n (n = 1..31) is a read/write register at byte address 4*(n-1). Its low 5 bits hold a source number, and a value of 0 means the slot is empty.
- R5: A write to 0x190 sets level-enable bits and a write to 0x194 clears them, both write-one. A read of 0x190 returns the word. Bit n enables slot n.
- R6: While level-enable bit 0 (freeze) is set, `cpu_irq` and `irq_vector` keep their values.
- R7: Configuration word k (k = 1..30) is at byte address 4*k + B. B is 0xA4 for k = 1..7, 0xE0 for k = 8..26, 0x58 for k = 27..28 and 0x64 for k = 29..30. Bit 0 selects edge sense (1) or level sense (0). Bit 1 selects active low. Bit 2 enables the source.
- R8: An edge source latches on its active edge once that edge has passed the two-flop synchronizer, and the request stays set after the input returns. A level source follows the synchronized input XOR its polarity bit.
- R9: A read of 0x180 returns the active sources: pending AND source enable AND configuration enable.
- R10: `cpu_irq` is 1 when any enabled slot holds an active source. `irq_vector` is the source in the lowest-numbered such slot, or 0 if there is none. Both are registered.
- R11: When a clear write and a new active edge for the same source fall in one cycle, the request stays set.
- R12: Reads of unmapped addresses return 0. Writes to them, and to the read-only addresses 0x180 and 0x198, change nothing. A read of 0x198 returns the current vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Raw request lines, asynchronous |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 5 | Source number of the most urgent request |

## Verification
The bench aims at the slot ordering when two assigned sources are active at once. A resolver that scanned in the wrong direction, or went by bit position, would return the wrong source. It drives a clear write into the same cycle that a new edge latches. A design that let the clear win would silently drop that event. It reads back configuration words at every range boundary of the irregular map, and also at the gaps between ranges, where a wrong base would alias a neighbour or answer a read that should return zero. It holds the freeze bit while the inputs change and expects a frozen vector. Random slot, enable and polarity programming is compared against a bench model of status, line and vector.

// File: rtl/picx_pkg.sv
package picx_pkg;
  parameter int NSRC   = 32;
  parameter int ADDR_W = 9;
  parameter int DATA_W = 32;
  localparam int SW    = $clog2(NSRC);
  localparam int CFG_W = 3;

  localparam logic [ADDR_W-1:0] A_STATUS = 9'h180;
  localparam logic [ADDR_W-1:0] A_EN_SET = 9'h184;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 9'h188;
  localparam logic [ADDR_W-1:0] A_SRCCLR = 9'h18C;
  localparam logic [ADDR_W-1:0] A_PL_SET = 9'h190;
  localparam logic [ADDR_W-1:0] A_PL_CLR = 9'h194;
  localparam logic [ADDR_W-1:0] A_VECTOR = 9'h198;

  typedef struct packed {
    logic en;
    logic act_low;
    logic edge_mode;
  } src_cfg_t;

  // Irregular per-range base of the configuration words.
  function automatic logic [ADDR_W-1:0] cfg_addr(input int k);
    int base;
    if (k <= 7)       base = 'hA4;
    else if (k <= 26) base = 'hE0;
    else if (k <= 28) base = 'h58;
    else              base = 'h64;
    return ADDR_W'(base + 4 * k);
  endfunction

  // Returns {hit, index} for a configuration word address.
  function automatic logic [SW:0] cfg_decode(input logic [ADDR_W-1:0] a);
    logic [SW:0] r;
    r = '0;
    for (int k = 1; k <= NSRC - 2; k++)
      if (a == cfg_addr(k)) r = {1'b1, SW'(k)};
    return r;
  endfunction

  // Returns {hit, slot} for a priority slot address.
  function automatic logic [SW:0] slot_decode(input logic [ADDR_W-1:0] a);
    logic [SW:0] r;
    r = '0;
    if (a[1:0] == 2'b00 && int'(a) < 4 * (NSRC - 1))
      r = {1'b1, SW'(a[ADDR_W-1:2]) + SW'(1)};
    return r;
  endfunction
endpackage

// File: rtl/picx_src_cond.sv
module picx_src_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic edge_mode,
  input  logic act_low,
  input  logic clr,
  output logic pend
);
  logic [2:0] sh_q;
  logic       lat_q;
  logic       cur, prev, hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], raw};

  assign cur  = sh_q[1] ^ act_low;
  assign prev = sh_q[2] ^ act_low;
  assign hit  = edge_mode & cur & ~prev;

  // A fresh edge outranks a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   lat_q <= 1'b0;
    else if (hit) lat_q <= 1'b1;
    else if (clr) lat_q <= 1'b0;

  assign pend = edge_mode ? lat_q : cur;
endmodule

// File: rtl/picx_regs.sv
module picx_regs
  import picx_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       we,
  input  logic [NSRC-1:0]            status,
  input  logic [SW-1:0]              vec,
  output logic [DATA_W-1:0]          rdata,
  output logic [NSRC-1:0]            en_mask,
  output logic [NSRC-1:0]            lvl_en,
  output logic [NSRC-1:0][SW-1:0]    slots,
  output src_cfg_t [NSRC-1:0]        cfg,
  output logic [NSRC-1:0]            src_clr
);
  logic [SW:0] cdec, sdec;
  assign cdec = cfg_decode(addr);
  assign sdec = slot_decode(addr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_mask <= '0;
      lvl_en  <= '0;
    end else if (we) begin
      if (addr == A_EN_SET) en_mask <= en_mask | wdata[NSRC-1:0];
      if (addr == A_EN_CLR) en_mask <= en_mask & ~wdata[NSRC-1:0];
      if (addr == A_PL_SET) lvl_en  <= lvl_en | wdata[NSRC-1:0];
      if (addr == A_PL_CLR) lvl_en  <= lvl_en & ~wdata[NSRC-1:0];
    end

  for (genvar k = 0; k < NSRC; k++) begin : g_per
    if (k == 0) begin : g_none
      assign slots[k] = '0;
      assign cfg[k]   = '0;
    end else begin : g_slot
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) slots[k] <= '0;
        else if (we && sdec[SW] && sdec[SW-1:0] == SW'(k))
          slots[k] <= wdata[SW-1:0];
      if (k == NSRC - 1) begin : g_fixed
        assign cfg[k] = '{en: 1'b1, act_low: 1'b0, edge_mode: 1'b0};
      end else begin : g_cfg
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) cfg[k] <= '0;
          else if (we && cdec[SW] && cdec[SW-1:0] == SW'(k))
            cfg[k] <= src_cfg_t'(wdata[CFG_W-1:0]);
      end
    end
  end

  assign src_clr = (we && addr == A_SRCCLR) ? wdata[NSRC-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (addr == A_STATUS)      rdata = DATA_W'(status);
    else if (addr == A_EN_SET) rdata = DATA_W'(en_mask);
    else if (addr == A_PL_SET) rdata = DATA_W'(lvl_en);
    else if (addr == A_VECTOR) rdata = DATA_W'(vec);
    else if (sdec[SW])         rdata = DATA_W'(slots[sdec[SW-1:0]]);
    else if (cdec[SW])         rdata = DATA_W'(cfg[cdec[SW-1:0]]);
  end
endmodule

// File: rtl/picx_resolve.sv
module picx_resolve
  import picx_pkg::*;
(
  input  logic [NSRC-1:0]         active,
  input  logic [NSRC-1:0]         lvl_en,
  input  logic [NSRC-1:0][SW-1:0] slots,
  output logic                    any,
  output logic [SW-1:0]           vec
);
  always_comb begin
    any = 1'b0;
    vec = '0;
    // Scan from least to most urgent; slot 1 ends up winning.
    for (int n = NSRC - 1; n >= 1; n--)
      if (lvl_en[n] && slots[n] != '0 && active[slots[n]]) begin
        any = 1'b1;
        vec = slots[n];
      end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import picx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_irq,
  output logic [SW-1:0]     irq_vector
);
  logic [NSRC-1:0]         en_mask, lvl_en, src_clr, pend, active, cfg_en;
  logic [NSRC-1:0][SW-1:0] slots;
  src_cfg_t [NSRC-1:0]     cfg;
  logic                    any;
  logic [SW-1:0]           vec_d;

  picx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .status(active), .vec(irq_vector), .rdata(bus_rdata), .en_mask(en_mask),
    .lvl_en(lvl_en), .slots(slots), .cfg(cfg), .src_clr(src_clr)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    picx_src_cond u_cond (
      .clk(clk), .rst_n(rst_n), .raw(irq_in[k]), .edge_mode(cfg[k].edge_mode),
      .act_low(cfg[k].act_low), .clr(src_clr[k]), .pend(pend[k])
    );
    assign cfg_en[k] = cfg[k].en;
  end

  assign active = pend & en_mask & cfg_en;

  picx_resolve u_res (
    .active(active), .lvl_en(lvl_en), .slots(slots), .any(any), .vec(vec_d)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpu_irq    <= 1'b0;
      irq_vector <= '0;
    end else if (!lvl_en[0]) begin
      cpu_irq    <= any;
      irq_vector <= vec_d;
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import picx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NSRC-1:0]   en_mask,
  input logic [NSRC-1:0]   lvl_en,
  input logic              cpu_irq,
  input logic [SW-1:0]     irq_vector
);
  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_EN_SET) |=>
      ((en_mask & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_EN_CLR) |=> ((en_mask & $past(bus_wdata[NSRC-1:0])) == '0));
  // R5
  lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PL_SET) |=>
      ((lvl_en & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_en[0] |=> ($stable(irq_vector) && $stable(cpu_irq)));
  // R10
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq |-> irq_vector == '0);
  // R10
  busy_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> irq_vector != '0);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en_mask(en_mask), .lvl_en(lvl_en),
  .cpu_irq(cpu_irq), .irq_vector(irq_vector)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  logic [4:0]  irq_vector;

  always #10 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .irq_vector(irq_vector)
  );

  int total = 0;
  int bad   = 0;

  logic [31:0] en_m, pl_m;
  logic [4:0]  slot_m [32];
  logic [2:0]  cfg_m  [32];

  function automatic logic [8:0] cfg_at(input int k);
    int b;
    if (k <= 7) b = 'hA4; else if (k <= 26) b = 'hE0; else if (k <= 28) b = 'h58; else b = 'h64;
    return 9'(b + 4 * k);
  endfunction

  function automatic logic [31:0] m_active();
    logic [31:0] a;
    for (int k = 0; k < 32; k++) begin
      logic p, e;
      if (k == 0)       begin p = 1'b0; e = 1'b0; end
      else if (k == 31) begin p = irq_in[31]; e = 1'b1; end
      else              begin p = irq_in[k] ^ cfg_m[k][1]; e = cfg_m[k][2]; end
      a[k] = p & e & en_m[k];
    end
    return a;
  endfunction

  function automatic logic [4:0] m_vec();
    logic [31:0] a;
    logic [4:0]  v;
    a = m_active();
    v = '0;
    for (int n = 31; n >= 1; n--)
      if (pl_m[n] && slot_m[n] != 0 && a[slot_m[n]]) v = slot_m[n];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog: run did not end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, st;
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; irq_in = '0;
    en_m = '0; pl_m = '0;
    for (int i = 0; i < 32; i++) begin slot_m[i] = '0; cfg_m[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(cpu_irq), 0);
    chk("R1 vector", 32'(irq_vector), 0);
    rd(9'h180, d); chk("R1 status", d, 0);
    rd(9'h184, d); chk("R1 enables", d, 0);
    rd(9'h190, d); chk("R1 level enables", d, 0);
    rd(9'h000, d); chk("R1 slot1", d, 0);
    rd(cfg_at(12), d); chk("R1 cfg12", d, 0);

    // R12 unmapped reads
    rd(9'h1FC, d); chk("R12 unmapped 1FC", d, 0);
    rd(9'h0A4, d); chk("R12 unmapped A4", d, 0);
    rd(9'h0CC, d); chk("R12 unmapped CC", d, 0);

    // R7 configuration map at range edges
    wr(cfg_at(7), 32'h7);  wr(cfg_at(8), 32'h5);
    wr(cfg_at(26), 32'h6); wr(cfg_at(27), 32'h3);
    wr(cfg_at(29), 32'h4); wr(cfg_at(30), 32'h2);
    wr(9'h0CC, 32'h1);
    wr(9'h180, 32'hFFFF_FFFF);
    rd(9'h0C0, d); chk("R7 cfg7 at C0", d, 7);
    rd(9'h100, d); chk("R7 cfg8 at 100", d, 5);
    rd(9'h148, d); chk("R7 cfg26 at 148", d, 6);
    rd(9'h0C4, d); chk("R7 cfg27 at C4", d, 3);
    rd(9'h0D8, d); chk("R7 cfg29 at D8", d, 4);
    rd(9'h0DC, d); chk("R7 cfg30 at DC", d, 2);
    rd(9'h0CC, d); chk("R12 write to gap ignored", d, 0);
    rd(9'h180, d); chk("R12 status not writable", d, 0);
    foreach (cfg_m[k]) if (k >= 1 && k <= 30) begin wr(cfg_at(k), 32'h4); cfg_m[k] = 3'h4; end

    // R2 R4 R5 R9 R10 random programming of level sources
    for (int it = 0; it < 60; it++) begin
      for (int j = 0; j < 3; j++) begin
        int op, n;
        op = int'($urandom % 6);
        d  = $urandom;
        case (op)
          0: begin n = 1 + int'($urandom % 31); wr(9'(4 * (n - 1)), d); slot_m[n] = d[4:0]; end
          1: begin wr(9'h184, d); en_m = en_m | d; end
          2: begin wr(9'h188, d); en_m = en_m & ~d; end
          3: begin d[0] = 1'b0; wr(9'h190, d); pl_m = pl_m | d; end
          4: begin wr(9'h194, d); pl_m = pl_m & ~d; end
          default: begin
            n = 1 + int'($urandom % 30);
            d = {29'd0, d[2:1], 1'b0};
            wr(cfg_at(n), d); cfg_m[n] = d[2:0];
          end
        endcase
      end
      irq_in = $urandom;
      settle();
      rd(9'h180, st); chk("R9 status", st, m_active());
      chk("R10 irq line", 32'(cpu_irq), 32'(m_vec() != 0));
      chk("R10 vector", 32'(irq_vector), 32'(m_vec()));
      if (it % 6 == 0) begin
        int n;
        n = 1 + int'($urandom % 31);
        rd(9'(4 * (n - 1)), d); chk("R4 slot readback", d, 32'(slot_m[n]));
        rd(9'h184, d); chk("R2 enable readback", d, en_m);
        rd(9'h190, d); chk("R5 level enable readback", d, pl_m);
        rd(9'h198, d); chk("R12 vector register", d, 32'(m_vec()));
      end
      if (it % 8 == 0) begin
        wr(9'h18C, 32'hFFFF_FFFF);
        settle();
        rd(9'h180, d); chk("R3 clear leaves levels", d, st);
      end
    end

    // R8 edge latch, rising polarity
    irq_in = '0;
    wr(9'h188, 32'hFFFF_FFFF); wr(9'h194, 32'hFFFF_FFFF);
    wr(cfg_at(5), 32'h5); wr(9'h008, 32'd5); wr(9'h190, 32'h8); wr(9'h184, 32'h20);
    wr(9'h18C, 32'hFFFF_FFFF);
    settle();
    chk("R8 idle before edge", 32'(cpu_irq), 0);
    @(negedge clk) irq_in[5] = 1'b1;
    repeat (3) @(negedge clk);
    irq_in[5] = 1'b0;
    settle();
    rd(9'h180, d); chk("R8 edge held after input drops", d, 32'h20);
    chk("R8 vector", 32'(irq_vector), 5);
    wr(9'h18C, 32'h20);
    settle();
    rd(9'h180, d); chk("R3 edge request cleared", d, 0);
    chk("R3 irq drops", 32'(cpu_irq), 0);

    // R11 clear and new edge in one cycle
    @(negedge clk) irq_in[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_addr = 9'h18C; bus_wdata = 32'h20; bus_we = 1'b1;
    @(negedge clk) bus_we = 1'b0;
    settle();
    rd(9'h180, d); chk("R11 edge beats clear", d, 32'h20);
    wr(9'h18C, 32'h20);
    settle();
    rd(9'h180, d); chk("R3 later clear", d, 0);

    // R8 falling polarity edge
    wr(cfg_at(5), 32'h7);
    settle();
    rd(9'h180, d); chk("R8 no edge on polarity change", d, 0);
    @(negedge clk) irq_in[5] = 1'b0;
    settle();
    rd(9'h180, d); chk("R8 falling edge latched", d, 32'h20);
    wr(9'h18C, 32'h20);

    // R10 slot ordering, R5 level gating
    wr(cfg_at(8), 32'h4); wr(cfg_at(27), 32'h4);
    wr(9'h004, 32'd27); wr(9'h014, 32'd8);
    wr(9'h190, 32'h44); wr(9'h184, 32'h0800_0100);
    irq_in = 32'h0800_0100;
    settle();
    chk("R10 slot2 beats slot6", 32'(irq_vector), 27);
    wr(9'h194, 32'h4);
    settle();
    chk("R5 disabled level skipped", 32'(irq_vector), 8);

    // R6 freeze
    wr(9'h190, 32'h1);
    irq_in = '0;
    settle();
    chk("R6 vector frozen", 32'(irq_vector), 8);
    chk("R6 irq frozen", 32'(cpu_irq), 1);
    wr(9'h194, 32'h1);
    settle();
    chk("R6 release updates", 32'(irq_vector), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule